// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits on the memory side of a coherent system and owns a group of cache lines. For each line it keeps a state, a sharer mask with one bit per processor, an owner id and one word of line data. Caches send it share or exclusive requests on one channel. On a second channel they return invalidation acknowledgements and dirty data. The controller answers with data replies, recall requests to an owner, and a single multicast invalidation that names every sharer that must give up its copy.

A line is in one of four states. In shared-readable, memory is valid and the mask lists the sharers; an empty mask means no cache holds the line. In owned, a single site holds a modified copy. The other two states are transient. One collects invalidation acknowledgements and the other waits for an owner to return its data. A new request to a line in a transient state waits at the request input until the line settles. Responses are never held back, so they can always complete the pending transaction.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every line is shared-readable with an empty mask and data 0, `out_valid` and `inv_valid` are 0 and `req_ready` is 1.
- R2: A share request (`req_ex`=0) to a shared-readable line yields, one cycle after acceptance, a share reply (`out_kind`=0) to the requester carrying the line data, and adds the requester to the mask.
- R3: An exclusive request (`req_ex`=1) to a shared-readable line with no sharer other than the requester yields an exclusive reply (`out_kind`=1) one cycle after acceptance. This covers both the empty mask and the requester as sole sharer. The requester becomes owner.
- R4: An exclusive request to a shared-readable line with other sharers raises `inv_valid` one cycle after acceptance. `inv_mask` then lists those sharers without the requester, and the line enters the acknowledgement-wait state.
- R5: Each invalidation acknowledgement (`rsp_kind`=0) removes its sender from the mask. The one that empties the mask produces an exclusive reply with the line data to the waiting requester on the next cycle, and the requester becomes owner. Earlier acknowledgements produce no output.
- R6: A share request to an owned line sends a write-back request (`out_kind`=2) to the owner. The owner's write-back data (`rsp_kind`=1) is stored and returned in a share reply to the requester. The line becomes shared-readable with the old owner and the requester as sharers.
- R7: An exclusive request to an owned line sends a flush request (`out_kind`=3) to the owner. The flush data (`rsp_kind`=2) is stored and returned in an exclusive reply to the requester, who becomes the new owner.
- R8: While the addressed line is in a transient state `req_ready` is 0. Requests to other lines are still accepted.
- R9: `req_ready` is 0 in any cycle where `rsp_valid` is 1.
- R10: A response whose kind does not match what the addressed line is waiting for produces no output and changes neither state nor data.
- R11: `out_valid` and `inv_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_ex | input | 1 | 0 share request, 1 exclusive request |
| req_src | input | $clog2(NPROC) | Requesting site |
| req_line | input | $clog2(NLINES) | Line index |
| rsp_valid | input | 1 | Response present (always accepted) |
| rsp_kind | input | 2 | 0 invalidation ack, 1 write-back data, 2 flush data |
| rsp_src | input | $clog2(NPROC) | Responding site |
| rsp_line | input | $clog2(NLINES) | Line index |
| rsp_data | input | DW | Returned line data |
| out_valid | output | 1 | Outgoing message present |
| out_kind | output | 2 | 0 share reply, 1 exclusive reply, 2 write-back request, 3 flush request |
| out_dst | output | $clog2(NPROC) | Destination site |
| out_line | output | $clog2(NLINES) | Line index |
| out_data | output | DW | Line data for replies |
| inv_valid | output | 1 | Multicast invalidation present |
| inv_line | output | $clog2(NLINES) | Line to invalidate |
| inv_mask | output | NPROC | Sites to invalidate |

## Verification
The hardest case to reach from the ports is a line that goes through both transient states, with ownership passing from one site to another. A recall then has to return data that is not the reset value. The stimulus first builds a line with several sharers and claims it exclusively. It drains the acknowledgements one at a time and checks for silence until the last one. It then recalls the line with a share request and a write-back of a fresh pattern. After that, a further exclusive request must multicast to exactly the old owner and the new sharer. A flush then hands the line to a third site. While the line is transient, request readiness is probed on that line and on an unrelated one.

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl #(
  parameter int NPROC  = 4,
  parameter int NLINES = 8,
  parameter int DW     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_ex,
  input  logic [$clog2(NPROC)-1:0]  req_src,
  input  logic [$clog2(NLINES)-1:0] req_line,
  input  logic                      rsp_valid,
  input  logic [1:0]                rsp_kind,
  input  logic [$clog2(NPROC)-1:0]  rsp_src,
  input  logic [$clog2(NLINES)-1:0] rsp_line,
  input  logic [DW-1:0]             rsp_data,
  output logic                      out_valid,
  output logic [1:0]                out_kind,
  output logic [$clog2(NPROC)-1:0]  out_dst,
  output logic [$clog2(NLINES)-1:0] out_line,
  output logic [DW-1:0]             out_data,
  output logic                      inv_valid,
  output logic [$clog2(NLINES)-1:0] inv_line,
  output logic [NPROC-1:0]          inv_mask
);
  localparam int PW = $clog2(NPROC);
  localparam logic [1:0] M_SHREP = 2'd0, M_EXREP = 2'd1, M_WBREQ = 2'd2, M_FLREQ = 2'd3;
  localparam logic [1:0] A_INV = 2'd0, A_WB = 2'd1, A_FL = 2'd2;

  typedef enum logic [1:0] {L_RD, L_OWN, L_WACK, L_WDAT} lstate_t;

  lstate_t          st  [NLINES];
  logic [NPROC-1:0] shv [NLINES];
  logic [PW-1:0]    own [NLINES];
  logic [PW-1:0]    pnd [NLINES];
  logic             pex [NLINES];
  logic [DW-1:0]    mem [NLINES];

  logic [NPROC-1:0] rbit, others, left, abit, obit;
  logic busy, take;

  assign rbit      = NPROC'(1) << req_src;
  assign others    = shv[req_line] & ~rbit;
  assign abit      = NPROC'(1) << rsp_src;
  assign left      = shv[rsp_line] & ~abit;
  assign obit      = NPROC'(1) << own[rsp_line];
  assign busy      = (st[req_line] == L_WACK) || (st[req_line] == L_WDAT);
  assign req_ready = !rsp_valid && !busy;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st[i]  <= L_RD;
        shv[i] <= '0;
        own[i] <= '0;
        pnd[i] <= '0;
        pex[i] <= 1'b0;
        mem[i] <= '0;
      end
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_dst   <= '0;
      out_line  <= '0;
      out_data  <= '0;
      inv_valid <= 1'b0;
      inv_line  <= '0;
      inv_mask  <= '0;
    end else begin
      out_valid <= 1'b0;
      inv_valid <= 1'b0;
      if (rsp_valid) begin
        out_line <= rsp_line;
        if (st[rsp_line] == L_WACK && rsp_kind == A_INV) begin
          shv[rsp_line] <= left;
          if (left == '0) begin
            st[rsp_line]  <= L_OWN;
            own[rsp_line] <= pnd[rsp_line];
            out_valid     <= 1'b1;
            out_kind      <= M_EXREP;
            out_dst       <= pnd[rsp_line];
            out_data      <= mem[rsp_line];
          end
        end else if (st[rsp_line] == L_WDAT &&
                     rsp_kind == (pex[rsp_line] ? A_FL : A_WB)) begin
          mem[rsp_line] <= rsp_data;
          out_valid     <= 1'b1;
          out_dst       <= pnd[rsp_line];
          out_data      <= rsp_data;
          if (pex[rsp_line]) begin
            st[rsp_line]  <= L_OWN;
            own[rsp_line] <= pnd[rsp_line];
            out_kind      <= M_EXREP;
          end else begin
            st[rsp_line]  <= L_RD;
            shv[rsp_line] <= obit | (NPROC'(1) << pnd[rsp_line]);
            out_kind      <= M_SHREP;
          end
        end
      end else if (take) begin
        out_line      <= req_line;
        inv_line      <= req_line;
        pnd[req_line] <= req_src;
        pex[req_line] <= req_ex;
        if (st[req_line] == L_RD) begin
          if (!req_ex) begin
            shv[req_line] <= shv[req_line] | rbit;
            out_valid     <= 1'b1;
            out_kind      <= M_SHREP;
            out_dst       <= req_src;
            out_data      <= mem[req_line];
          end else if (others == '0) begin
            st[req_line]  <= L_OWN;
            own[req_line] <= req_src;
            shv[req_line] <= '0;
            out_valid     <= 1'b1;
            out_kind      <= M_EXREP;
            out_dst       <= req_src;
            out_data      <= mem[req_line];
          end else begin
            st[req_line]  <= L_WACK;
            shv[req_line] <= others;
            inv_valid     <= 1'b1;
            inv_mask      <= others;
          end
        end else begin
          st[req_line] <= L_WDAT;
          out_valid    <= 1'b1;
          out_kind     <= req_ex ? M_FLREQ : M_WBREQ;
          out_dst      <= own[req_line];
          out_data     <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/home_dir_chk.sv
module home_dir_chk #(
  parameter int NPROC  = 4,
  parameter int NLINES = 8,
  parameter int DW     = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_ex,
  input logic [$clog2(NPROC)-1:0]  req_src,
  input logic [$clog2(NLINES)-1:0] req_line,
  input logic                      rsp_valid,
  input logic                      out_valid,
  input logic [1:0]                out_kind,
  input logic                      inv_valid,
  input logic [$clog2(NLINES)-1:0] inv_line,
  input logic [NPROC-1:0]          inv_mask
);
  // R11
  single_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, inv_valid}));

  // R4
  inv_excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_mask != '0) && !inv_mask[$past(req_src)] && inv_line == $past(req_line));

  // R2
  share_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_ex) |=> out_valid && (out_kind == 2'd0 || out_kind == 2'd2));

  // R3
  excl_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_ex) |=> inv_valid || (out_valid && (out_kind == 2'd1 || out_kind == 2'd3)));

  // R9
  rsp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind home_dir_ctrl home_dir_chk #(.NPROC(NPROC), .NLINES(NLINES), .DW(DW)) u_chk (.*);

// File: tb/sim_home_dir_ctrl.sv
module sim_home_dir_ctrl;
  localparam int NPROC = 4, NLINES = 8, DW = 16;
  localparam int PW = $clog2(NPROC), LW = $clog2(NLINES);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ex = 0, rsp_valid = 0;
  logic [PW-1:0] req_src = 0, rsp_src = 0;
  logic [LW-1:0] req_line = 0, rsp_line = 0;
  logic [1:0] rsp_kind = 0;
  logic [DW-1:0] rsp_data = 0;
  logic req_ready, out_valid, inv_valid;
  logic [1:0] out_kind;
  logic [PW-1:0] out_dst;
  logic [LW-1:0] out_line, inv_line;
  logic [DW-1:0] out_data;
  logic [NPROC-1:0] inv_mask;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  home_dir_ctrl #(.NPROC(NPROC), .NLINES(NLINES), .DW(DW)) u0 (.*);

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic send_req(logic ex, int src, int line);
    @(negedge clk);
    req_valid = 1; req_ex = ex; req_src = PW'(src); req_line = LW'(line);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_rsp(int kind, int src, int line, logic [DW-1:0] d);
    @(negedge clk);
    rsp_valid = 1; rsp_kind = 2'(kind); rsp_src = PW'(src); rsp_line = LW'(line); rsp_data = d;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic expect_out(string r, int kind, int dst, int line, logic [DW-1:0] d);
    check(r, {31'd0, out_valid}, 1);
    check(r, {31'd0, inv_valid}, 0);
    check(r, 32'(out_kind), 32'(kind));
    check(r, 32'(out_dst), 32'(dst));
    check(r, 32'(out_line), 32'(line));
    if (kind < 2) check(r, 32'(out_data), 32'(d));
  endtask

  task automatic expect_quiet(string r);
    check(r, {30'd0, out_valid, inv_valid}, 0);
  endtask

  task automatic expect_inv(string r, int line, logic [NPROC-1:0] m);
    check(r, {31'd0, inv_valid}, 1);
    check(r, {31'd0, out_valid}, 0);
    check(r, 32'(inv_line), 32'(line));
    check(r, 32'(inv_mask), 32'(m));
  endtask

  task automatic peek_ready(string r, int line, logic exp);
    @(negedge clk);
    req_valid = 1; req_ex = 0; req_src = 3; req_line = LW'(line);
    #1 check(r, {31'd0, req_ready}, {31'd0, exp});
    req_valid = 0;
  endtask

  task automatic t_reset;
    check("R1", {30'd0, out_valid, inv_valid}, 0);
    check("R1", {31'd0, req_ready}, 1);
  endtask

  task automatic t_share;
    send_req(0, 1, 0); expect_out("R2", 0, 1, 0, 0);
    send_req(0, 2, 0); expect_out("R2", 0, 2, 0, 0);
  endtask

  task automatic t_invalidate;
    send_req(1, 1, 0); expect_inv("R4", 0, 4'b0100);
    peek_ready("R8", 0, 0);
    peek_ready("R8", 1, 1);
    send_req(0, 3, 1); expect_out("R8", 0, 3, 1, 0);
    send_rsp(0, 2, 0, 0); expect_out("R5", 1, 1, 0, 0);
    send_req(0, 0, 3); send_req(0, 2, 3); send_req(0, 3, 3);
    send_req(1, 1, 3); expect_inv("R4", 3, 4'b1101);
    send_rsp(0, 0, 3, 0); expect_quiet("R5");
    send_rsp(0, 2, 3, 0); expect_quiet("R5");
    send_rsp(0, 3, 3, 0); expect_out("R5", 1, 1, 3, 0);
  endtask

  task automatic t_direct_excl;
    send_req(1, 2, 4); expect_out("R3", 1, 2, 4, 0);
    send_req(0, 3, 5); expect_out("R2", 0, 3, 5, 0);
    send_req(1, 3, 5); expect_out("R3", 1, 3, 5, 0);
  endtask

  task automatic t_recall;
    send_req(0, 3, 0); expect_out("R6", 2, 1, 0, 0);
    send_rsp(1, 1, 0, 16'hBEEF); expect_out("R6", 0, 3, 0, 16'hBEEF);
    send_req(1, 0, 0); expect_inv("R6", 0, 4'b1010);
    send_rsp(0, 1, 0, 0); expect_quiet("R5");
    send_rsp(0, 3, 0, 0); expect_out("R6", 1, 0, 0, 16'hBEEF);
    send_req(1, 2, 0); expect_out("R7", 3, 0, 0, 0);
    send_rsp(2, 0, 0, 16'h1234); expect_out("R7", 1, 2, 0, 16'h1234);
    send_req(0, 1, 0); expect_out("R7", 2, 2, 0, 0);
  endtask

  task automatic t_stray;
    send_rsp(0, 1, 4, 0); expect_quiet("R10");
    send_req(0, 0, 4); expect_out("R10", 2, 2, 4, 0);
    send_rsp(1, 1, 6, 16'h5555); expect_quiet("R10");
    send_req(0, 1, 6); expect_out("R10", 0, 1, 6, 0);
  endtask

  task automatic t_priority;
    @(negedge clk);
    rsp_valid = 1; rsp_kind = 0; rsp_src = 0; rsp_line = 7;
    req_valid = 1; req_ex = 0; req_src = 1; req_line = 7;
    #1 check("R9", {31'd0, req_ready}, 0);
    @(negedge clk);
    rsp_valid = 0; req_valid = 0;
    expect_quiet("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_share;
    t_invalidate;
    t_direct_excl;
    t_recall;
    t_stray;
    t_priority;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule